// File: doc/BRIEF.md
# Horizontal Drive Pulse Generator with Safety Gating

This block produces the line-rate drive pulse for a scanning output stage. Each horizontal period begins with an off interval, during which the external switch does not conduct. The interval's length is a fraction of the period, set by a 5-bit duty code. The block then holds the drive high for the rest of the period. The period is learned by counting clock cycles between reference ticks. In forced mode it is instead generated internally at twice or three times the free-running rate.

The pulse is gated by four safety conditions: low supply, a latched X-ray fault, the flyback interval, and a software enable. Any of them forces the drive low from the next clock edge. The B+ converter inhibit follows the same gating, except for flyback. The X-ray fault is held in a latch. Only a software clear pulse, given while the comparator input is low, or a loss of supply releases it. The latch state is reported as a status bit.

The block has no streaming data path. All pins are plain control and status levels, sampled on the rising clock edge and assumed to be synchronous to `clk`.

Top module: `hdrive_gate`

## Requirements
- R1: With a period of L cycles and duty code c, the off interval is floor(L·3·(31+c)/310) cycles. The drive is low for that many cycles from the period start, then high until the period ends. Code 0 gives 30 % and code 31 gives 60 %. The code is taken at each period start.
- R2: After reset, until the first period start, the block uses L = FREE_CYC and code 31, so the off interval is 60 % whatever the code input says.
- R3: In normal mode a period starts on the clock edge that samples `line_tick` high. L is the number of cycles since the previous start.
- R4: If no new period start arrives, the drive goes low once L cycles have elapsed and stays low.
- R5: With `force_en` = 1 the period is FREE_CYC/2 cycles (`force_x3` = 0) or FREE_CYC/3 cycles (`force_x3` = 1). `line_tick` is ignored in this mode.
- R6: `flyback` high at a clock edge forces `hdrive` low in the following cycle.
- R7: `supply_ok` low at a clock edge forces `hdrive` low and `bplus_off` high in the following cycle, and clears the X-ray latch.
- R8: `drive_en` low at a clock edge forces `hdrive` low and `bplus_off` high in the following cycle.
- R9: `xray_trip` high at an edge (with supply present) sets the latch. `xray_stat` reads 1 from the next cycle and stays 1 after the trip input drops. While it is 1, `hdrive` is low and `bplus_off` is high.
- R10: `xray_clr` high clears the latch only when `xray_trip` is low at the same edge. A trip present at that edge wins.
- R11: An inhibit that ends inside the off interval leaves the pulse unchanged. An inhibit only ever removes high cycles from the drive and never adds any.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_tick | input | 1 | One-cycle horizontal period reference |
| force_en | input | 1 | Use the internal forced period instead of the ticks |
| force_x3 | input | 1 | Forced rate: 0 selects 2x, 1 selects 3x |
| duty_code | input | DUTY_W | Off-time code, 0 = 30 %, 31 = 60 % |
| drive_en | input | 1 | Software drive enable |
| supply_ok | input | 1 | Supply above the operating threshold |
| flyback | input | 1 | Flyback interval active |
| xray_trip | input | 1 | X-ray comparator output |
| xray_clr | input | 1 | Software X-ray latch clear |
| hdrive | output | 1 | Horizontal drive, 1 = conduct |
| bplus_off | output | 1 | B+ converter inhibit |
| xray_stat | output | 1 | X-ray latch state |

## Verification
Every cycle, the assertions check the safety paths: each inhibit input pulls the drive low one cycle later, the X-ray latch sets, holds and yields only as specified, and a latched fault keeps both outputs in their safe state. Duty arithmetic, the reset default, period learning, the late-tick cutoff and the forced-rate periods depend on whole-period counts. Only the bench's scenarios can show these, by counting high cycles and rising edges over windows of known length.

// File: rtl/hdrv_pkg.sv
package hdrv_pkg;

  // Off interval in cycles: len * (30 % + code * 30 % / cmax)
  function automatic int unsigned off_cycles(input int unsigned len,
                                             input int unsigned code,
                                             input int unsigned cmax);
    return (len * 3 * (cmax + code)) / (10 * cmax);
  endfunction

endpackage

// File: rtl/hdrv_period.sv
module hdrv_period #(
  parameter int CNT_W    = 12,
  parameter int FREE_CYC = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_tick,
  input  logic             force_en,
  input  logic             force_x3,
  output logic             start,
  output logic [CNT_W-1:0] len_nxt,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] len
);

  localparam logic [CNT_W-1:0] FLEN2 = CNT_W'(FREE_CYC / 2);
  localparam logic [CNT_W-1:0] FLEN3 = CNT_W'(FREE_CYC / 3);
  localparam logic [CNT_W-1:0] FREE  = CNT_W'(FREE_CYC);

  logic [CNT_W-1:0] flen;

  always_comb begin
    flen  = force_x3 ? FLEN3 : FLEN2;
    start = force_en ? (cnt >= flen - 1'b1) : line_tick;
    if (force_en)  len_nxt = flen;
    else if (&cnt) len_nxt = cnt;
    else           len_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      len <= FREE;
    end else if (start) begin
      cnt <= '0;
      len <= len_nxt;
    end else if (!(&cnt)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/hdrv_duty.sv
module hdrv_duty #(
  parameter int CNT_W    = 12,
  parameter int DUTY_W   = 5,
  parameter int FREE_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len_nxt,
  input  logic [DUTY_W-1:0] code,
  output logic [CNT_W-1:0]  off_len
);

  localparam int unsigned CMAX = (1 << DUTY_W) - 1;
  localparam logic [CNT_W-1:0] OFF_RST =
    CNT_W'(hdrv_pkg::off_cycles(FREE_CYC, CMAX, CMAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      off_len <= OFF_RST;
    else if (start)
      off_len <= CNT_W'(hdrv_pkg::off_cycles(32'(len_nxt), 32'(code), CMAX));
  end

endmodule

// File: rtl/hdrv_safety.sv
module hdrv_safety (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic flyback,
  input  logic drive_en,
  input  logic xray_trip,
  input  logic xray_clr,
  output logic inh,
  output logic bp_off,
  output logic xlat
);

  logic xlat_nxt;

  always_comb begin
    if (!supply_ok)     xlat_nxt = 1'b0;
    else if (xray_trip) xlat_nxt = 1'b1;
    else if (xray_clr)  xlat_nxt = 1'b0;
    else                xlat_nxt = xlat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat   <= 1'b0;
      inh    <= 1'b1;
      bp_off <= 1'b1;
    end else begin
      xlat   <= xlat_nxt;
      bp_off <= !supply_ok || !drive_en || xlat_nxt;
      inh    <= !supply_ok || !drive_en || xlat_nxt || flyback;
    end
  end

endmodule

// File: rtl/hdrive_gate.sv
module hdrive_gate #(
  parameter int CNT_W    = 12,
  parameter int DUTY_W   = 5,
  parameter int FREE_CYC = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              force_en,
  input  logic              force_x3,
  input  logic [DUTY_W-1:0] duty_code,
  input  logic              drive_en,
  input  logic              supply_ok,
  input  logic              flyback,
  input  logic              xray_trip,
  input  logic              xray_clr,
  output logic              hdrive,
  output logic              bplus_off,
  output logic              xray_stat
);

  logic             start;
  logic [CNT_W-1:0] len_nxt;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] off_len;
  logic             inh;

  hdrv_period #(.CNT_W(CNT_W), .FREE_CYC(FREE_CYC)) i_period (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .force_en(force_en), .force_x3(force_x3),
    .start(start), .len_nxt(len_nxt), .cnt(cnt), .len(len)
  );

  hdrv_duty #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .FREE_CYC(FREE_CYC)) i_duty (
    .clk(clk), .rst_n(rst_n), .start(start), .len_nxt(len_nxt),
    .code(duty_code), .off_len(off_len)
  );

  hdrv_safety i_safety (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .flyback(flyback),
    .drive_en(drive_en), .xray_trip(xray_trip), .xray_clr(xray_clr),
    .inh(inh), .bp_off(bplus_off), .xlat(xray_stat)
  );

  // Conduct between the end of the off interval and the end of the period.
  assign hdrive = (cnt >= off_len) && (cnt < len) && !inh;

endmodule

// File: rtl/hdrive_gate_chk.sv
module hdrive_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic drive_en,
  input logic supply_ok,
  input logic flyback,
  input logic xray_trip,
  input logic xray_clr,
  input logic hdrive,
  input logic bplus_off,
  input logic xray_stat
);

  // R6
  flyback_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flyback) |-> !hdrive);

  // R7
  supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(supply_ok) |-> (!hdrive && bplus_off && !xray_stat));

  // R8
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(drive_en) |-> (!hdrive && bplus_off));

  // R9
  xray_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xray_trip) && $past(supply_ok)) |-> xray_stat);

  // R10
  xray_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(xray_stat) && !$past(xray_clr) && $past(supply_ok)) |-> xray_stat);

  // R9
  xray_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xray_stat |-> (!hdrive && bplus_off));

endmodule

bind hdrive_gate hdrive_gate_chk i_chk (.*);

// File: tb/test_hdrive_gate.sv
`timescale 1ns/1ps
module test_hdrive_gate;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_tick = 1'b0;
  logic       force_en = 1'b0;
  logic       force_x3 = 1'b0;
  logic [4:0] duty_code = 5'd0;
  logic       drive_en = 1'b1;
  logic       supply_ok = 1'b1;
  logic       flyback = 1'b0;
  logic       xray_trip = 1'b0;
  logic       xray_clr = 1'b0;
  logic       hdrive, bplus_off, xray_stat;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  hdrive_gate i_hdrive_gate (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .force_en(force_en),
    .force_x3(force_x3), .duty_code(duty_code), .drive_en(drive_en),
    .supply_ok(supply_ok), .flyback(flyback), .xray_trip(xray_trip),
    .xray_clr(xray_clr), .hdrive(hdrive), .bplus_off(bplus_off),
    .xray_stat(xray_stat)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_high(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (hdrive) highs++;
    end
  endtask

  // Three tick-driven periods of n cycles; the last one is measured.
  task automatic run_normal(input int n, input int code, input int fb_lo,
                            input int fb_hi, output int highs);
    duty_code = 5'(code);
    force_en = 1'b0;
    highs = 0;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        line_tick = (i == n - 1);
        flyback = (p == 2) && (i >= fb_lo) && (i < fb_hi);
        if (p == 2 && hdrive) highs++;
      end
    end
    flyback = 1'b0;
  endtask

  task automatic t_reset();
    int h;
    count_high(400, h);
    chk("R2 reset duty 60% high cycles", h, 120);
    chk("R9 reset xray_stat", int'(xray_stat), 0);
    chk("R8 reset bplus_off", int'(bplus_off), 0);
  endtask

  task automatic t_duty();
    int h;
    run_normal(100, 0, 0, 0, h);
    chk("R1 R3 code 0 period 100", h, 70);
    run_normal(100, 31, 0, 0, h);
    chk("R1 code 31 period 100", h, 40);
    run_normal(100, 15, 0, 0, h);
    chk("R1 code 15 period 100", h, 56);
    run_normal(80, 16, 0, 0, h);
    chk("R1 R3 code 16 period 80", h, 44);
  endtask

  task automatic t_late();
    int h;
    run_normal(100, 0, 0, 0, h);
    @(negedge clk);
    line_tick = 1'b0;
    count_high(99, h);
    chk("R4 period runs on after last tick", h, 70);
    count_high(100, h);
    chk("R4 drive low once period elapses", h, 0);
  endtask

  task automatic t_flyback();
    int h;
    run_normal(100, 0, 50, 60, h);
    chk("R6 flyback during on phase", h, 60);
    run_normal(100, 0, 10, 20, h);
    chk("R11 flyback inside off interval", h, 70);
    run_normal(100, 0, 25, 35, h);
    chk("R11 flyback straddling off end", h, 64);
  endtask

  task automatic t_forced(input bit x3, input int code, input int exp_h,
                          input int exp_r, input string req);
    int h, r;
    bit prev;
    force_en = 1'b1;
    force_x3 = x3;
    duty_code = 5'(code);
    repeat (400) @(negedge clk);
    prev = hdrive;
    h = 0;
    r = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      line_tick = (i % 7 == 0);
      if (hdrive) h++;
      if (hdrive && !prev) r++;
      prev = hdrive;
    end
    line_tick = 1'b0;
    chk({req, " high cycles"}, h, exp_h);
    chk({req, " pulse count"}, r, exp_r);
  endtask

  task automatic t_enable();
    int h;
    @(negedge clk);
    drive_en = 1'b0;
    @(negedge clk);
    chk("R8 bplus_off with drive disabled", int'(bplus_off), 1);
    count_high(100, h);
    chk("R8 no drive when disabled", h, 0);
    drive_en = 1'b1;
    @(negedge clk);
    count_high(100, h);
    chk("R8 drive back when enabled", h, 40);
  endtask

  task automatic t_xray();
    int h;
    @(negedge clk);
    xray_trip = 1'b1;
    @(negedge clk);
    xray_trip = 1'b0;
    chk("R9 latch set", int'(xray_stat), 1);
    chk("R9 bplus_off on fault", int'(bplus_off), 1);
    count_high(100, h);
    chk("R9 no drive while latched", h, 0);
    chk("R9 latch held after trip drops", int'(xray_stat), 1);
    xray_trip = 1'b1;
    xray_clr = 1'b1;
    @(negedge clk);
    xray_clr = 1'b0;
    xray_trip = 1'b0;
    chk("R10 trip beats clear", int'(xray_stat), 1);
    @(negedge clk);
    xray_clr = 1'b1;
    @(negedge clk);
    xray_clr = 1'b0;
    chk("R10 clear releases latch", int'(xray_stat), 0);
    chk("R10 bplus_off released", int'(bplus_off), 0);
    count_high(100, h);
    chk("R10 drive resumes", h, 40);
  endtask

  task automatic t_supply();
    int h;
    @(negedge clk);
    xray_trip = 1'b1;
    @(negedge clk);
    xray_trip = 1'b0;
    supply_ok = 1'b0;
    chk("R9 latch set before power loss", int'(xray_stat), 1);
    @(negedge clk);
    chk("R7 latch cleared by supply low", int'(xray_stat), 0);
    chk("R7 bplus_off on supply low", int'(bplus_off), 1);
    count_high(100, h);
    chk("R7 no drive on supply low", h, 0);
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R7 latch stays clear after power return", int'(xray_stat), 0);
    chk("R7 bplus_off released", int'(bplus_off), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_duty();
    t_late();
    t_flyback();
    t_forced(1'b0, 31, 120, 2, "R5 forced 2x code 31");
    t_forced(1'b0, 0, 210, 2, "R5 forced 2x code 0");
    t_forced(1'b1, 31, 120, 3, "R5 forced 3x code 31");
    t_enable();
    t_xray();
    t_supply();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule